// File: doc/BRIEF.md
# SD Host FIFO Watermark and DMA Request Unit

This unit sits next to the 32-word, 16-bit data FIFO of an SD/MMC host controller. It watches the FIFO occupancy reported by the FIFO and compares it against two programmable watermarks. In the card-to-host direction it looks for a FIFO that is filling up. In the host-to-card direction it looks for a FIFO that is running dry. Each watermark crossing becomes one of two things, selected by a per-direction DMA enable. It is either a hardware-owned flag in the 16-bit status word, which software polls or takes as an interrupt, or a level DMA request line.

The same status word also collects one-cycle event pulses from the rest of the host. Those bits are sticky and are cleared by software with a write-one-to-clear. A mask word selects which status bits drive the single interrupt line. Both watermark flags and both DMA requests are forced low while the host is idle and the FIFO is empty.

Top module: `sdh_fifo_watch`

## Requirements
- R1: After reset, the status word, the mask word, both DMA requests and the interrupt are 0. The fill watermark resets to 31 and the drain watermark resets to 0.
- R2: With readDir=1 and rxDmaEn=0, a FIFO count strictly greater than the fill watermark sets status bit 10 one clock later and keeps rxDmaReq low.
- R3: With readDir=1 and rxDmaEn=1, the same condition raises rxDmaReq one clock later and keeps status bit 10 low.
- R4: With readDir=0 and txDmaEn=0, a FIFO count strictly less than the drain watermark sets status bit 11 one clock later and keeps txDmaReq low.
- R5: With readDir=0 and txDmaEn=1, the same condition raises txDmaReq one clock later and keeps status bit 11 low.
- R6: When a direction's condition does not hold, that direction's status bit and DMA request are low one clock later. This includes a count equal to the watermark and the opposite transfer direction.
- R7: When xferActive=0 and the FIFO count is 0, status bits 10 and 11 and both DMA requests are low one clock later, whatever the watermarks say.
- R8: irq is high exactly when some bit of (status AND mask) is set. A mask write takes effect one clock later.
- R9: For every status bit other than 10 and 11, a statusSet pulse sets it and a clear write with a 1 in that position clears it. If both happen in the same cycle, the set wins. statusSet bits 10 and 11 are ignored.
- R10: A clear write to bit 10 or 11 has no effect while that bit's watermark condition still holds.
- R11: A watermark write (thrWrEn) is used by the compare from the following clock onward. The compare in the write cycle itself uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoCount | input | 6 | Current FIFO occupancy, 0 to 32 words |
| xferActive | input | 1 | A data transfer is in progress |
| readDir | input | 1 | 1 = card to host (fill watch), 0 = host to card (drain watch) |
| rxDmaEn | input | 1 | Route the fill crossing to rxDmaReq instead of status bit 10 |
| txDmaEn | input | 1 | Route the drain crossing to txDmaReq instead of status bit 11 |
| thrWrEn | input | 1 | Load both watermarks |
| thrFillIn | input | 5 | New fill watermark |
| thrDrainIn | input | 5 | New drain watermark |
| maskWrEn | input | 1 | Load the interrupt mask |
| maskIn | input | 16 | New interrupt mask |
| clrWrEn | input | 1 | Write-one-to-clear strobe for the status word |
| clrIn | input | 16 | Bits to clear |
| statusSet | input | 16 | One-cycle event pulses that set sticky status bits |
| status | output | 16 | Status word |
| rxDmaReq | output | 1 | Receive DMA request level |
| txDmaReq | output | 1 | Transmit DMA request level |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The bench builds the unit with its default parameters: a 32-word FIFO, 5-bit watermarks and a 16-bit status word with the flags at bits 10 and 11. With these values the count can reach 32, one above the largest watermark. That puts the reset fill watermark of 31 at a true boundary, so counts of 31 and 32 separate "equal" from "greater". The drain watermark of 0 shows that the drain condition can never fire until software programs it. A count sweep from 0 to 32 against a mid-range watermark covers every compare outcome in one pass.

// File: rtl/sdh_fifo_watch_pkg.sv
package sdh_fifo_watch_pkg;

  // Strobes from the compare/control half to the register datapath
  typedef struct packed {
    logic idleEmpty;  // host idle and FIFO empty
    logic fillHit;    // fill watermark condition holds (already gated by idleEmpty)
    logic drainHit;   // drain watermark condition holds (already gated by idleEmpty)
    logic rxUseDma;   // route fill crossing to DMA
    logic txUseDma;   // route drain crossing to DMA
  } lvlStrobe_t;

endpackage

// File: rtl/sdh_fifo_watch_ctrl.sv
module sdh_fifo_watch_ctrl
  import sdh_fifo_watch_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             xferActive,
  input  logic             readDir,
  input  logic             rxDmaEn,
  input  logic             txDmaEn,
  input  logic             thrWrEn,
  input  logic [THR_W-1:0] thrFillIn,
  input  logic [THR_W-1:0] thrDrainIn,
  output lvlStrobe_t       strobe
);

  localparam logic [THR_W-1:0] FILL_RST  = THR_W'(DEPTH - 1);
  localparam logic [THR_W-1:0] DRAIN_RST = '0;

  logic [THR_W-1:0] fillLevel;
  logic [THR_W-1:0] drainLevel;
  logic             idleEmpty;
  logic             fillCmp;
  logic             drainCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillLevel  <= FILL_RST;
      drainLevel <= DRAIN_RST;
    end else if (thrWrEn) begin
      fillLevel  <= thrFillIn;
      drainLevel <= thrDrainIn;
    end
  end

  always_comb begin
    idleEmpty = !xferActive && (fifoCount == '0);
    fillCmp   = fifoCount > CNT_W'(fillLevel);
    drainCmp  = fifoCount < CNT_W'(drainLevel);
    strobe.idleEmpty = idleEmpty;
    strobe.fillHit   = !idleEmpty && readDir && fillCmp;
    strobe.drainHit  = !idleEmpty && !readDir && drainCmp;
    strobe.rxUseDma  = rxDmaEn;
    strobe.txUseDma  = txDmaEn;
  end

  // R11: a watermark write is held from the next clock
  assert_thr_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    thrWrEn |=> (fillLevel == $past(thrFillIn)) && (drainLevel == $past(thrDrainIn)));

  // R6: the two directions never report a crossing together
  assert_dir_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.fillHit && strobe.drainHit));

endmodule

// File: rtl/sdh_fifo_watch_dp.sv
module sdh_fifo_watch_dp
  import sdh_fifo_watch_pkg::*;
#(
  parameter int STAT_W    = 16,
  parameter int FILL_BIT  = 10,
  parameter int DRAIN_BIT = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  lvlStrobe_t        strobe,
  input  logic              maskWrEn,
  input  logic [STAT_W-1:0] maskIn,
  input  logic              clrWrEn,
  input  logic [STAT_W-1:0] clrIn,
  input  logic [STAT_W-1:0] statusSet,
  output logic [STAT_W-1:0] status,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              irq
);

  localparam logic [STAT_W-1:0] HW_MASK =
    (STAT_W'(1) << FILL_BIT) | (STAT_W'(1) << DRAIN_BIT);
  localparam logic [STAT_W-1:0] SW_MASK = ~HW_MASK;

  logic [STAT_W-1:0] maskReg;
  logic [STAT_W-1:0] clrEff;
  logic              fillFlag;
  logic              drainFlag;

  assign clrEff    = clrWrEn ? clrIn : '0;
  assign fillFlag  = strobe.fillHit && !strobe.rxUseDma;
  assign drainFlag = strobe.drainHit && !strobe.txUseDma;

  // One register per status bit; hardware-owned bits follow their level,
  // the rest are sticky with set-over-clear priority.
  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == FILL_BIT) begin : g_fill
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) status[i] <= 1'b0;
        else       status[i] <= fillFlag;
      end
    end else if (i == DRAIN_BIT) begin : g_drain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) status[i] <= 1'b0;
        else       status[i] <= drainFlag;
      end
    end else begin : g_sticky
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             status[i] <= 1'b0;
        else if (statusSet[i]) status[i] <= 1'b1;
        else if (clrEff[i])    status[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDmaReq <= 1'b0;
      txDmaReq <= 1'b0;
      maskReg  <= '0;
    end else begin
      rxDmaReq <= strobe.fillHit && strobe.rxUseDma;
      txDmaReq <= strobe.drainHit && strobe.txUseDma;
      if (maskWrEn) maskReg <= maskIn;
    end
  end

  assign irq = |(status & maskReg);

  assert_rx_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDmaReq && status[FILL_BIT]));

  assert_tx_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(txDmaReq && status[DRAIN_BIT]));

  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idleEmpty |=> !rxDmaReq && !txDmaReq && !status[FILL_BIT] && !status[DRAIN_BIT]);

  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrEn && maskIn == '0) |=> !irq);

  assert_set_sticks_R9: assert property (@(posedge clk) disable iff (!rstN)
    |(statusSet & SW_MASK) |=>
      ((status & $past(statusSet & SW_MASK)) == $past(statusSet & SW_MASK)));

  assert_hold_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillHit && !strobe.rxUseDma) |=> status[FILL_BIT]);

endmodule

// File: rtl/sdh_fifo_watch.sv
module sdh_fifo_watch
  import sdh_fifo_watch_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int STAT_W    = 16,
  parameter int FILL_BIT  = 10,
  parameter int DRAIN_BIT = 11,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic              xferActive,
  input  logic              readDir,
  input  logic              rxDmaEn,
  input  logic              txDmaEn,
  input  logic              thrWrEn,
  input  logic [THR_W-1:0]  thrFillIn,
  input  logic [THR_W-1:0]  thrDrainIn,
  input  logic              maskWrEn,
  input  logic [STAT_W-1:0] maskIn,
  input  logic              clrWrEn,
  input  logic [STAT_W-1:0] clrIn,
  input  logic [STAT_W-1:0] statusSet,
  output logic [STAT_W-1:0] status,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              irq
);

  lvlStrobe_t strobe;

  sdh_fifo_watch_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fifoCount  (fifoCount),
    .xferActive (xferActive),
    .readDir    (readDir),
    .rxDmaEn    (rxDmaEn),
    .txDmaEn    (txDmaEn),
    .thrWrEn    (thrWrEn),
    .thrFillIn  (thrFillIn),
    .thrDrainIn (thrDrainIn),
    .strobe     (strobe)
  );

  sdh_fifo_watch_dp #(
    .STAT_W    (STAT_W),
    .FILL_BIT  (FILL_BIT),
    .DRAIN_BIT (DRAIN_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .maskWrEn  (maskWrEn),
    .maskIn    (maskIn),
    .clrWrEn   (clrWrEn),
    .clrIn     (clrIn),
    .statusSet (statusSet),
    .status    (status),
    .rxDmaReq  (rxDmaReq),
    .txDmaReq  (txDmaReq),
    .irq       (irq)
  );

endmodule

// File: tb/tb_sdh_fifo_watch.sv
`timescale 1ns/1ps
module tb_sdh_fifo_watch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  fifoCount = '0;
  logic        xferActive = 1'b0, readDir = 1'b0, rxDmaEn = 1'b0, txDmaEn = 1'b0;
  logic        thrWrEn = 1'b0;
  logic [4:0]  thrFillIn = '0, thrDrainIn = '0;
  logic        maskWrEn = 1'b0, clrWrEn = 1'b0;
  logic [15:0] maskIn = '0, clrIn = '0, statusSet = '0;
  logic [15:0] status;
  logic        rxDmaReq, txDmaReq, irq;

  sdh_fifo_watch dut (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] st;
    logic rx, tx, ir;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, bad = 0;
  logic finished = 1'b0;

  // Reference state kept from the requirements
  logic [15:0] mStatus = '0, mMask = '0;
  logic [4:0]  mFill = 5'd31, mDrain = 5'd0;

  task automatic cycle(input string tag);
    expItem_t it;
    logic idle, fHit, dHit;
    logic [15:0] nxt;
    idle = !xferActive && fifoCount == 0;
    fHit = !idle && readDir && (fifoCount > {1'b0, mFill});
    dHit = !idle && !readDir && (fifoCount < {1'b0, mDrain});
    nxt = mStatus & ~(clrWrEn ? clrIn : 16'h0);
    nxt = nxt | statusSet;
    nxt[10] = fHit && !rxDmaEn;
    nxt[11] = dHit && !txDmaEn;
    mStatus = nxt;
    if (maskWrEn) mMask = maskIn;
    if (thrWrEn) begin mFill = thrFillIn; mDrain = thrDrainIn; end
    it.st = mStatus; it.rx = fHit && rxDmaEn; it.tx = dHit && txDmaEn;
    it.ir = |(mStatus & mMask); it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    thrWrEn = 0; maskWrEn = 0; clrWrEn = 0; statusSet = '0;
  endtask

  // Monitor: compares one item per clock just after the edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        total++;
        if (status !== e.st || rxDmaReq !== e.rx || txDmaReq !== e.tx || irq !== e.ir) begin
          bad++;
          $display("FAIL %s: got st=%h rx=%b tx=%b irq=%b exp st=%h rx=%b tx=%b irq=%b",
                   e.tag, status, rxDmaReq, txDmaReq, irq, e.st, e.rx, e.tx, e.ir);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    total++;
    if (status !== 16'h0 || rxDmaReq !== 1'b0 || txDmaReq !== 1'b0 || irq !== 1'b0) begin
      bad++;
      $display("FAIL R1: got st=%h rx=%b tx=%b irq=%b exp all zero", status, rxDmaReq, txDmaReq, irq);
    end
    rstN = 1;
    @(negedge clk);

    xferActive = 1; readDir = 1;
    fifoCount = 31; cycle("R1 fill reset 31, count equal");
    fifoCount = 32; cycle("R2 count above fill");
    clrWrEn = 1; clrIn = 16'h0400; cycle("R10 clear ignored while fill holds");
    fifoCount = 20; cycle("R6 fill condition gone");
    rxDmaEn = 1; fifoCount = 32; cycle("R3 rx dma request");
    cycle("R3 rx dma held");
    fifoCount = 31; cycle("R6 rx request drops at equal");

    readDir = 0; rxDmaEn = 0; fifoCount = 0; cycle("R1 drain reset 0 never fires");
    thrWrEn = 1; thrFillIn = 5'd4; thrDrainIn = 5'd8; fifoCount = 3;
    cycle("R11 old drain used in write cycle");
    cycle("R4 drain flag after new watermark");
    clrWrEn = 1; clrIn = 16'h0800; cycle("R10 clear ignored while drain holds");
    txEnSet: begin txDmaEn = 1; end
    cycle("R5 tx dma request");
    fifoCount = 8; cycle("R6 drain equal clears");
    txDmaEn = 0; fifoCount = 5; readDir = 1; cycle("R6 read dir ignores drain, R2 fill");
    readDir = 0; fifoCount = 0; cycle("R4 drain while active, empty");
    xferActive = 0; cycle("R7 idle empty clears");
    readDir = 1; rxDmaEn = 1; cycle("R7 idle empty no rx req");
    rxDmaEn = 0;

    statusSet = 16'h0C09; cycle("R9 set sticky bits, hw bits ignored");
    cycle("R9 sticky bits held");
    maskWrEn = 1; maskIn = 16'h0020; cycle("R8 mask misses");
    maskWrEn = 1; maskIn = 16'h0008; cycle("R8 mask hits");
    clrWrEn = 1; clrIn = 16'h0008; cycle("R9 clear bit 3, R8 irq drops");
    statusSet = 16'h0001; clrWrEn = 1; clrIn = 16'h0001; cycle("R9 set wins over clear");
    clrWrEn = 1; clrIn = 16'hFFFF; cycle("R9 clear all");

    xferActive = 1; readDir = 0; fifoCount = 2;
    maskWrEn = 1; maskIn = 16'h0800; cycle("R8 irq from drain flag");
    maskWrEn = 1; maskIn = 16'h0000; cycle("R8 mask zero");

    thrWrEn = 1; thrFillIn = 5'd15; thrDrainIn = 5'd0; readDir = 1; fifoCount = 0;
    cycle("R11 load fill 15");
    for (int c = 0; c <= 32; c++) begin
      fifoCount = 6'(c);
      cycle(c > 15 ? "R2 sweep above" : "R6 sweep at or below");
    end

    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule